// File: doc/BRIEF.md
# Cipher Trigger and Status Controller

This block is the control front end of a block-cipher accelerator. Software writes a six-bit action word into a write-only trigger register. The block turns the pending action bits into one-cycle strobes toward the datapath: one that launches a data block, and wipe strobes for the key, IV, input-data and output-data banks. It also fetches a fresh seed for an internal LFSR, which supplies the pseudo-random fill word written into a bank when it is wiped. Each action bit returns to zero by itself once its action is done.

The trigger register comes out of reset with every wipe bit and the reseed bit set. The block therefore reseeds and wipes all banks by itself right after reset, and it reports busy during that work. A four-bit read-only status word reports idle, stall, output-valid and input-ready. The cipher rounds are outside the block: a launch strobe goes out, and a done pulse comes back from the datapath.

The sequencer is a state machine with five states. `S_IDLE` picks the next action. `S_RESEED` holds the entropy request until it is acknowledged. `S_WIPE` wipes one bank per cycle. `S_LAUNCH` emits the start strobe. `S_RUN` waits for the datapath's done pulse. Its transitions are:
- `S_IDLE` goes to `S_RESEED` when reseed is pending.
- Otherwise `S_IDLE` goes to `S_WIPE` when any wipe is pending.
- Otherwise `S_IDLE` goes to `S_LAUNCH` when start is pending, manual mode is on and the unit is not stalled.
- `S_RESEED` goes to `S_IDLE` on acknowledge.
- `S_WIPE` stays in `S_WIPE` while wipes remain and no reseed is pending, and goes to `S_IDLE` otherwise.
- `S_LAUNCH` always goes to `S_RUN`.
- `S_RUN` goes to `S_IDLE` on done.

Top module: `cipher_trig_ctrl`

## Requirements
- R1: Reset sets the pending action word to 6'b111110. The bit meanings are: bit 0 start, bit 1 key wipe, bit 2 IV wipe, bit 3 input wipe, bit 4 output wipe, bit 5 reseed. Status is {bit3 input ready, bit2 output valid, bit1 stall, bit0 idle}. It reads 4'b1000 during the post-reset work and 4'b1001 once that work is done.
- R2: A pending reseed raises `ent_req_o`, which stays high until `ent_ack_i`. On acknowledge the LFSR loads `ent_data_i`. A zero word is replaced by the seed 32'h1ACEB00C.
- R3: Pending actions are serviced in this order: reseed, then key, IV, input and output wipes, then start. The wipes come on consecutive cycles, one bank per cycle. Each wipe is a one-cycle strobe, and no two strobes are ever high together.
- R4: While a wipe strobe is high, `fill_o` holds the LFSR state. After each wipe the LFSR takes one step: shift right, then XOR with 32'h80200003 if the bit shifted out was 1.
- R5: Each action bit self-clears. A write produces each requested action exactly once, and the block then stays quiet.
- R6: With manual mode on, a start produces one `start_o` pulse. Idle stays 0 from the launch until `core_done_i`.
- R7: A start while manual mode is off is dropped with no `start_o` pulse.
- R8: A write that arrives while the block is busy is ORed into the pending bits. It is serviced only after the current operation ends.
- R9: `din_wr_i` clears input ready (status bit 3). A launch or an input-bank wipe sets it again.
- R10: `core_done_i` sets output valid (status bit 2). `dout_rd_i` clears it, and so does an output-bank wipe.
- R11: A done while output valid is still set raises stall (status bit 1) and forces idle to 0. No start is launched while stalled. The next `dout_rd_i` clears stall and leaves output valid at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_wr_i | input | 1 | Trigger register write strobe |
| trig_data_i | input | 6 | Action bits written |
| manual_i | input | 1 | Manual-operation control setting |
| din_wr_i | input | 1 | Software wrote new input data |
| dout_rd_i | input | 1 | Software read the output data |
| core_done_i | input | 1 | Datapath finished a block |
| ent_ack_i | input | 1 | Entropy word valid |
| ent_data_i | input | 32 | Entropy word |
| ent_req_o | output | 1 | Entropy request |
| start_o | output | 1 | Launch one data block |
| key_wipe_o | output | 1 | Wipe key banks |
| iv_wipe_o | output | 1 | Wipe IV bank |
| din_wipe_o | output | 1 | Wipe input-data bank |
| dout_wipe_o | output | 1 | Wipe output-data bank |
| fill_o | output | 32 | Pseudo-random fill word |
| status_o | output | 4 | {input ready, output valid, stall, idle} |

## Verification
The assertions check these rules on every cycle:
- No two strobes are ever high together.
- Every start follows a cycle with manual mode on.
- The entropy request is held until it is acknowledged.
- Stall never appears without output valid, and it rises only on a done.
- Idle drops after a launch.

Only the bench's scenarios can show the rest:
- The service order across a whole batch of actions.
- That the wipes fall on consecutive cycles.
- The exact fill sequence after a reseed, including the substitution for a zero entropy word.
- The post-reset sequence.
- That a write arriving during a run is deferred.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
    localparam int NACT       = 6;
    localparam int NWIPE      = 4;
    localparam int ACT_START  = 0;
    localparam int ACT_KEY    = 1;
    localparam int ACT_RESEED = 5;
    localparam logic [NACT-1:0] TRIG_RST = 6'b111110;

    localparam int ST_IDLE  = 0;
    localparam int ST_STALL = 1;
    localparam int ST_OVAL  = 2;
    localparam int ST_IRDY  = 3;
    localparam int NSTAT    = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RESEED,
        S_WIPE,
        S_LAUNCH,
        S_RUN
    } ctc_state_e;
endpackage

// File: rtl/ctc_prng.sv
module ctc_prng #(
    parameter int          W    = 32,
    parameter logic [W-1:0] TAPS = 32'h80200003,
    parameter logic [W-1:0] SEED = 32'h1ACEB00C
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rs_req_i,
    input  logic         ent_ack_i,
    input  logic [W-1:0] ent_data_i,
    input  logic         adv_i,
    output logic         ent_req_o,
    output logic         rs_done_o,
    output logic [W-1:0] fill_o
);
    logic [W-1:0] lfsr_q;
    logic [W-1:0] lfsr_step;

    assign ent_req_o = rs_req_i;
    assign rs_done_o = rs_req_i & ent_ack_i;
    assign fill_o    = lfsr_q;
    assign lfsr_step = {1'b0, lfsr_q[W-1:1]} ^ (lfsr_q[0] ? TAPS : '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
        end else if (rs_done_o) begin
            lfsr_q <= (ent_data_i == '0) ? SEED : ent_data_i;
        end else if (adv_i) begin
            lfsr_q <= lfsr_step;
        end
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_req_o && !ent_ack_i) |=> ent_req_o);
endmodule

// File: rtl/ctc_seq.sv
module ctc_seq
    import ctc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [NACT-1:0] wr_data_i,
    input  logic            manual_i,
    input  logic            stall_i,
    input  logic            core_done_i,
    input  logic            rs_done_i,
    output logic            rs_req_o,
    output logic            start_o,
    output logic [NWIPE-1:0] wipe_o,
    output logic            quiet_o
);
    ctc_state_e state_q, state_d;
    logic [NACT-1:0]  pend_q, pend_d, done_mask;
    logic [NWIPE-1:0] wipe_sel, wipe_rem;
    logic             any_wipe;

    // lowest pending wipe bit wins: key, IV, input, output
    always_comb begin
        wipe_sel = '0;
        for (int i = 0; i < NWIPE; i++) begin
            if (pend_q[ACT_KEY+i] && (wipe_sel == '0)) wipe_sel[i] = 1'b1;
        end
    end

    assign any_wipe = |pend_q[ACT_KEY +: NWIPE];
    assign wipe_rem = pend_q[ACT_KEY +: NWIPE] & ~wipe_sel;

    // state register and trigger register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pend_q  <= TRIG_RST;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (pend_q[ACT_RESEED])                             state_d = S_RESEED;
                else if (any_wipe)                                  state_d = S_WIPE;
                else if (pend_q[ACT_START] && manual_i && !stall_i) state_d = S_LAUNCH;
            end
            S_RESEED: if (rs_done_i) state_d = S_IDLE;
            S_WIPE:   if ((wipe_rem == '0) || pend_q[ACT_RESEED]) state_d = S_IDLE;
            S_LAUNCH: state_d = S_RUN;
            S_RUN:    if (core_done_i) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs and self-clearing of action bits
    always_comb begin
        rs_req_o  = 1'b0;
        start_o   = 1'b0;
        wipe_o    = '0;
        done_mask = '0;
        unique case (state_q)
            S_IDLE: begin
                if (!pend_q[ACT_RESEED] && !any_wipe && pend_q[ACT_START] && !manual_i)
                    done_mask[ACT_START] = 1'b1;
            end
            S_RESEED: begin
                rs_req_o = 1'b1;
                done_mask[ACT_RESEED] = rs_done_i;
            end
            S_WIPE: begin
                wipe_o = wipe_sel;
                done_mask[ACT_KEY +: NWIPE] = wipe_sel;
            end
            S_LAUNCH: begin
                start_o = 1'b1;
                done_mask[ACT_START] = 1'b1;
            end
            S_RUN:   ;
            default: ;
        endcase
        pend_d  = (pend_q & ~done_mask) | (wr_en_i ? wr_data_i : '0);
        quiet_o = (state_q == S_IDLE) && (pend_q == '0);
    end

    // R3
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, wipe_o}));
    // R7
    start_manual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(manual_i));
endmodule

// File: rtl/ctc_status.sv
module ctc_status
    import ctc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic             core_done_i,
    input  logic             din_wr_i,
    input  logic             dout_rd_i,
    input  logic             din_wipe_i,
    input  logic             dout_wipe_i,
    input  logic             quiet_i,
    output logic             stall_o,
    output logic [NSTAT-1:0] status_o
);
    logic in_pend_q, oval_q, stall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_pend_q <= 1'b0;
        end else if (din_wr_i) begin
            in_pend_q <= 1'b1;
        end else if (launch_i || din_wipe_i) begin
            in_pend_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oval_q  <= 1'b0;
            stall_q <= 1'b0;
        end else if (dout_wipe_i) begin
            oval_q  <= 1'b0;
            stall_q <= 1'b0;
        end else if (core_done_i) begin
            if (oval_q && !dout_rd_i) stall_q <= 1'b1;
            oval_q <= 1'b1;
        end else if (dout_rd_i) begin
            if (stall_q) stall_q <= 1'b0;
            else         oval_q  <= 1'b0;
        end
    end

    assign stall_o = stall_q;

    always_comb begin
        status_o           = '0;
        status_o[ST_IDLE]  = quiet_i && !stall_q;
        status_o[ST_STALL] = stall_q;
        status_o[ST_OVAL]  = oval_q;
        status_o[ST_IRDY]  = !in_pend_q;
    end

    // R11
    stall_needs_oval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_q |-> oval_q);
    // R11
    stall_from_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_q) |-> $past(core_done_i));
    // R6
    busy_after_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |=> !status_o[ST_IDLE]);
endmodule

// File: rtl/cipher_trig_ctrl.sv
module cipher_trig_ctrl
    import ctc_pkg::*;
#(
    parameter int           W    = 32,
    parameter logic [W-1:0] TAPS = 32'h80200003,
    parameter logic [W-1:0] SEED = 32'h1ACEB00C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_wr_i,
    input  logic [NACT-1:0]  trig_data_i,
    input  logic             manual_i,
    input  logic             din_wr_i,
    input  logic             dout_rd_i,
    input  logic             core_done_i,
    input  logic             ent_ack_i,
    input  logic [W-1:0]     ent_data_i,
    output logic             ent_req_o,
    output logic             start_o,
    output logic             key_wipe_o,
    output logic             iv_wipe_o,
    output logic             din_wipe_o,
    output logic             dout_wipe_o,
    output logic [W-1:0]     fill_o,
    output logic [NSTAT-1:0] status_o
);
    logic             rs_req, rs_done, quiet, stall;
    logic [NWIPE-1:0] wipe;

    ctc_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (trig_wr_i),
        .wr_data_i   (trig_data_i),
        .manual_i    (manual_i),
        .stall_i     (stall),
        .core_done_i (core_done_i),
        .rs_done_i   (rs_done),
        .rs_req_o    (rs_req),
        .start_o     (start_o),
        .wipe_o      (wipe),
        .quiet_o     (quiet)
    );

    ctc_prng #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_prng (
        .clk        (clk),
        .rst_n      (rst_n),
        .rs_req_i   (rs_req),
        .ent_ack_i  (ent_ack_i),
        .ent_data_i (ent_data_i),
        .adv_i      (|wipe),
        .ent_req_o  (ent_req_o),
        .rs_done_o  (rs_done),
        .fill_o     (fill_o)
    );

    ctc_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (start_o),
        .core_done_i (core_done_i),
        .din_wr_i    (din_wr_i),
        .dout_rd_i   (dout_rd_i),
        .din_wipe_i  (wipe[2]),
        .dout_wipe_i (wipe[3]),
        .quiet_i     (quiet),
        .stall_o     (stall),
        .status_o    (status_o)
    );

    assign key_wipe_o  = wipe[0];
    assign iv_wipe_o   = wipe[1];
    assign din_wipe_o  = wipe[2];
    assign dout_wipe_o = wipe[3];
endmodule

// File: tb/cipher_trig_ctrl_bench.sv
module cipher_trig_ctrl_bench;
    localparam logic [31:0] TAPS = 32'h80200003;
    localparam logic [31:0] SEED = 32'h1ACEB00C;
    // {manual, action word}
    localparam logic [6:0] VEC [6] = '{7'b1_000001, 7'b0_000001, 7'b1_111111,
                                       7'b0_010100, 7'b1_100001, 7'b1_001010};

    logic clk = 0, rst_n = 0;
    logic trig_wr = 0, manual = 0, din_wr = 0, dout_rd = 0, core_done = 0, ent_ack = 0;
    logic [5:0]  trig_data = 0;
    logic [31:0] ent_val = 32'hC0FFEE01;
    logic ent_req, start, kw, ivw, dw, ow;
    logic [31:0] fill;
    logic [3:0]  status;

    int total = 0, bad = 0, cyc = 0, nev = 0, ent_wait = 0, core_cnt = 0;
    bit auto_core = 1;
    int ev_k [256];
    int ev_c [256];
    logic [31:0] ev_f [256];
    logic [31:0] model = SEED;

    always #10 clk = ~clk;

    cipher_trig_ctrl u_cipher_trig_ctrl (
        .clk(clk), .rst_n(rst_n), .trig_wr_i(trig_wr), .trig_data_i(trig_data),
        .manual_i(manual), .din_wr_i(din_wr), .dout_rd_i(dout_rd), .core_done_i(core_done),
        .ent_ack_i(ent_ack), .ent_data_i(ent_val), .ent_req_o(ent_req), .start_o(start),
        .key_wipe_o(kw), .iv_wipe_o(ivw), .din_wipe_o(dw), .dout_wipe_o(ow),
        .fill_o(fill), .status_o(status));

    function automatic logic [31:0] lstep(logic [31:0] s);
        return {1'b0, s[31:1]} ^ (s[0] ? TAPS : 32'h0);
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic add_ev(int k, logic [31:0] f);
        if (nev < 256) begin
            ev_k[nev] = k; ev_c[nev] = cyc; ev_f[nev] = f;
        end
        nev++;
    endtask

    // event monitor, away from the active edge; R4 fill model
    always @(negedge clk) begin
        if (rst_n) begin
            if (ent_req && ent_ack) begin
                model = (ent_val == 0) ? SEED : ent_val;
                add_ev(5, model);
            end
            if (kw)    add_ev(1, fill);
            if (ivw)   add_ev(2, fill);
            if (dw)    add_ev(3, fill);
            if (ow)    add_ev(4, fill);
            if (start) add_ev(0, fill);
            if (kw || ivw || dw || ow) begin
                chk(fill == model, "R4 fill", fill, model);
                model = lstep(model);
            end
        end
    end

    always @(posedge clk) cyc++;

    task automatic tick();
        @(posedge clk); #1;
        trig_wr = 0; din_wr = 0; dout_rd = 0; core_done = 0;
        if (ent_req) begin
            ent_wait++;
            ent_ack = (ent_wait >= 2);
        end else begin
            ent_wait = 0; ent_ack = 0;
        end
        if (auto_core) begin
            if (start) core_cnt = 3;
            else if (core_cnt > 0) begin
                core_cnt--;
                if (core_cnt == 0) core_done = 1;
            end
        end
    endtask

    task automatic write_trig(logic [5:0] d);
        tick(); trig_wr = 1; trig_data = d;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            tick();
            if (status[0] && !trig_wr) break;
        end
    endtask

    task automatic cmp_events(int base, int exp_k [6], int ne, string req);
        chk(nev - base == ne, req, nev - base, ne);
        for (int i = 0; i < ne && i < nev - base; i++) begin
            chk(ev_k[base+i] == exp_k[i], req, ev_k[base+i], exp_k[i]);
            if (i > 0 && ev_k[base+i] >= 1 && ev_k[base+i] <= 4 &&
                ev_k[base+i-1] >= 1 && ev_k[base+i-1] <= 4)
                chk(ev_c[base+i] == ev_c[base+i-1] + 1, "R3 consecutive",
                    ev_c[base+i], ev_c[base+i-1] + 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base, ne, cnt;
        int ek [6];
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state: busy, input ready
        chk(status == 4'b1000, "R1 reset status", status, 4'b1000);
        base = 0;
        wait_idle();
        ek = '{5, 1, 2, 3, 4, 0};
        cmp_events(base, ek, 5, "R1 post-reset sequence");
        chk(status == 4'b1001, "R1 idle status", status, 4'b1001);
        chk(ev_f[1] == 32'hC0FFEE01, "R2 reseed load", ev_f[1], 32'hC0FFEE01);

        // table of action words
        foreach (VEC[v]) begin
            manual = VEC[v][6];
            ent_val = 32'h5A000000 + 32'(v) * 32'h01234567;
            base = nev; ne = 0;
            if (VEC[v][5]) begin ek[ne] = 5; ne++; end
            for (int b = 1; b <= 4; b++) if (VEC[v][b]) begin ek[ne] = b; ne++; end
            if (VEC[v][0] && VEC[v][6]) begin ek[ne] = 0; ne++; end
            write_trig(VEC[v][5:0]);
            wait_idle();
            cmp_events(base, ek, ne, "R3/R12 order R7");
            chk(status == {1'b1, VEC[v][0] & VEC[v][6], 2'b01}, "R6 R10 status",
                status, {1'b1, VEC[v][0] & VEC[v][6], 2'b01});
            repeat (5) tick();
            chk(nev - base == ne, "R5 self-clear", nev - base, ne);
            tick(); dout_rd = 1; tick();
            chk(status == 4'b1001, "R10 read clears", status, 4'b1001);
        end

        // R2 zero entropy word
        ent_val = 0; base = nev;
        write_trig(6'b100010);
        wait_idle();
        chk(nev - base == 2 && ev_f[base+1] == SEED, "R2 zero seed", ev_f[base+1], SEED);

        // R8 write during run deferred
        manual = 1; auto_core = 0; base = nev;
        write_trig(6'b000001);
        repeat (6) tick();
        write_trig(6'b000010);
        repeat (6) tick();
        chk(nev - base == 1, "R8 deferred", nev - base, 1);
        chk(status[0] == 0, "R6 busy", status[0], 0);
        core_done = 1;
        wait_idle();
        ek = '{0, 1, 0, 0, 0, 0};
        cmp_events(base, ek, 2, "R8 after done");
        chk(status[2] == 1, "R10 done sets valid", status[2], 1);
        auto_core = 1;

        // R10 output wipe clears valid
        write_trig(6'b010000);
        wait_idle();
        chk(status == 4'b1001, "R10 wipe clears", status, 4'b1001);

        // R9 input ready
        tick(); din_wr = 1; tick();
        chk(status[3] == 0, "R9 input pending", status[3], 0);
        write_trig(6'b000001);
        wait_idle();
        chk(status[3] == 1, "R9 launch loads", status[3], 1);
        tick(); din_wr = 1; tick();
        write_trig(6'b001000);
        wait_idle();
        chk(status[3] == 1, "R9 wipe restores", status[3], 1);

        // R11 stall: output still valid from the launch above
        base = nev;
        write_trig(6'b000001);
        repeat (15) tick();
        chk(status == 4'b1110, "R11 stall", status, 4'b1110);
        write_trig(6'b000001);
        repeat (10) tick();
        chk(nev - base == 1, "R11 no launch while stalled", nev - base, 1);
        dout_rd = 1; tick();
        chk(status[2:1] == 2'b10, "R11 read clears stall", status[2:1], 2'b10);
        repeat (15) tick();
        cnt = nev - base;
        chk(cnt == 2, "R11 launch after read", cnt, 2);
        dout_rd = 1; tick(); tick();
        dout_rd = 1; tick(); tick();
        chk(status == 4'b1001, "R11 drained", status, 4'b1001);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule